// File: doc/BRIEF.md
# Trailing-Edge Digital PWM Modulator

This block turns the signed control word produced by a voltage-loop compensator into a gate-drive pulse of fixed switching period. A free-running counter, clocked by the system clock, spans one switching period. The gate output goes high at the first count of every period. It drops when the counter reaches a compare value derived from the control word, and stays low until the period ends.

The control word is two's complement with one sign bit and eleven fraction bits. Words below zero request the smallest allowed pulse. Words of zero or more are scaled onto the period length and then clamped. The clamp keeps a short minimum on-time and a short minimum off-time in every period, even when the compensator saturates in either direction. The compare value is captured only on the clock edge that opens a period, so a word that changes in the middle of a pulse cannot shorten or split it.

A one-cycle strobe marks the first cycle of each period. The compensator can use it to pace its updates, so that a new word is ready before the next boundary.

Top module: `trail_pwm`

## Requirements
- R1: The switching period is exactly 1000 clock cycles, and `period_start` is high for exactly one cycle at the start of every period, in the cycle where the internal count is zero.
- R2: In every period `gate_out` is high from the first cycle of the period for exactly C consecutive cycles and low for the remaining 1000 − C cycles, so it has exactly one rising edge, at the period start. C is the compare value defined in R3 and R4.
- R3: For a word w whose bit 11 is 0, C = floor(w × 1000 / 2048), clamped into the range 9 to 987.
- R4: For a word whose bit 11 is 1 (negative in two's complement), C = 9, the minimum pulse, whatever the magnitude.
- R5: `ctrl_word` is sampled only on the clock edge that opens a period. Any value it takes between two such edges has no effect on the pulse of the period in progress.
- R6: Reset is synchronous and active low. While it is applied, `gate_out` and `period_start` are low and the internal count is zero.
- R7: The first period after reset is released starts on the first clock edge with `rst_n` high. On that edge `period_start` rises and the word then present on `ctrl_word` is captured.
- R8: Boundary values: word 0x7FF gives C = 987, word 0x000 gives C = 9, and word 885 gives C = 432 (about 43.2 % duty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one count per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_word | input | 12 | Signed control word, 1 sign bit and 11 fraction bits |
| gate_out | output | 1 | Trailing-edge PWM gate signal |
| period_start | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
On every cycle, the assertions check the following: the counter advances by one and wraps only at the last count; the latched compare value stays inside its clamp window; the compare value holds still between boundaries; the gate rises only together with the period strobe; a negative word captured at a boundary yields the minimum compare value; and reset forces the quiet state. The exact pulse width for a given word and the length of each period can only be shown by the bench. So can the fact that a mid-period change of the word reaches only the next period, and the restart after a reset taken in the middle of a period. The bench measures these by counting gate-high cycles between strobes, for directed extremes and for random words.

// File: rtl/pwm_pkg.sv
// Package: pwm_pkg
// Shared defaults for the trailing-edge PWM modulator. The constants are
// the switching period in clock cycles, the control-word width and the
// clamp window for the compare value.
package pwm_pkg;

    localparam int unsigned PWM_PERIOD_DEF  = 1000;
    localparam int unsigned PWM_CW_W_DEF    = 12;
    localparam int unsigned PWM_MIN_CMP_DEF = 9;
    localparam int unsigned PWM_MAX_CMP_DEF = 987;

endpackage : pwm_pkg

// File: rtl/pwm_period_ctr.sv
// Module: pwm_period_ctr
// Counts 0 .. PERIOD-1 and flags the edge that opens a new period.
// Assumes: synchronous active-low reset, PERIOD >= 2. The first edge after
// reset is also treated as a boundary, so a full period follows it.
module pwm_period_ctr #(
    parameter int unsigned PERIOD = pwm_pkg::PWM_PERIOD_DEF,
    parameter int unsigned CNT_W  = $clog2(PERIOD)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic armed_q;

    // Boundary when not yet running or at the last count of a period.
    always_comb begin
        wrap    = !armed_q || (cnt_q == LAST);
        cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    end

    // Count register and run flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_nxt;
            armed_q <= 1'b1;
        end
    end

    // R1: after the last count the counter returns to zero.
    p_wrap_to_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (cnt_q == '0));

    // R1: below the last count the counter steps by one once running.
    p_step_by_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R6: reset holds the counter at zero.
    p_reset_zero_r6: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0));

endmodule : pwm_period_ctr

// File: rtl/pwm_duty_map.sv
// Module: pwm_duty_map
// Maps a signed fraction word (1 sign bit, CW_W-1 fraction bits) onto a
// compare count in a PERIOD-count period: negative words map to MIN_CMP,
// other words to floor(w*PERIOD/2^(CW_W-1)) clamped into [MIN_CMP,MAX_CMP].
// Assumes: purely combinational, MIN_CMP <= MAX_CMP < PERIOD.
module pwm_duty_map #(
    parameter int unsigned CW_W    = pwm_pkg::PWM_CW_W_DEF,
    parameter int unsigned PERIOD  = pwm_pkg::PWM_PERIOD_DEF,
    parameter int unsigned MIN_CMP = pwm_pkg::PWM_MIN_CMP_DEF,
    parameter int unsigned MAX_CMP = pwm_pkg::PWM_MAX_CMP_DEF,
    parameter int unsigned CNT_W   = $clog2(PERIOD)
) (
    input  logic [CW_W-1:0]  ctrl_word,
    output logic [CNT_W-1:0] cmp_val
);

    localparam int unsigned FRAC   = CW_W - 1;
    localparam int unsigned PROD_W = CW_W + CNT_W;
    localparam logic [PROD_W-1:0] PERIOD_P = PROD_W'(PERIOD);
    localparam logic [PROD_W-1:0] MIN_P    = PROD_W'(MIN_CMP);
    localparam logic [PROD_W-1:0] MAX_P    = PROD_W'(MAX_CMP);

    logic              is_neg;
    logic [PROD_W-1:0] mag;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    // Scale the magnitude onto the period, then clamp.
    always_comb begin
        is_neg = ctrl_word[CW_W-1];
        mag    = PROD_W'(ctrl_word[CW_W-2:0]);
        prod   = mag * PERIOD_P;
        scaled = prod >> FRAC;
        if (is_neg || scaled < MIN_P)
            cmp_val = CNT_W'(MIN_CMP);
        else if (scaled > MAX_P)
            cmp_val = CNT_W'(MAX_CMP);
        else
            cmp_val = scaled[CNT_W-1:0];
    end

endmodule : pwm_duty_map

// File: rtl/pwm_edge_gen.sv
// Module: pwm_edge_gen
// Holds the compare value for the running period, loads a new one only at a
// boundary, and drives the registered gate and period strobe.
// Assumes: wrap/cnt_nxt come from pwm_period_ctr; synchronous active-low reset.
module pwm_edge_gen #(
    parameter int unsigned MIN_CMP = pwm_pkg::PWM_MIN_CMP_DEF,
    parameter int unsigned MAX_CMP = pwm_pkg::PWM_MAX_CMP_DEF,
    parameter int unsigned CNT_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cmp_q,
    output logic             gate_q,
    output logic             strobe_q
);

    logic [CNT_W-1:0] cmp_nxt;

    // Compare value in force for the next cycle.
    always_comb begin
        cmp_nxt = wrap ? cmp_val : cmp_q;
    end

    // Compare latch, gate and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= CNT_W'(MIN_CMP);
            gate_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            cmp_q    <= cmp_nxt;
            gate_q   <= (cnt_nxt < cmp_nxt);
            strobe_q <= wrap;
        end
    end

    // R3: the compare in force never leaves the clamp window.
    p_cmp_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_q >= CNT_W'(MIN_CMP)) && (cmp_q <= CNT_W'(MAX_CMP)));

    // R5: between boundaries the compare value does not move.
    p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cmp_q));

    // R2: the gate rises only in the first cycle of a period.
    p_rise_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_q) |-> strobe_q);

    // R2: the gate never falls in the first cycle of a period.
    p_fall_mid_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_q) |-> !strobe_q);

    // R6: reset leaves the gate and strobe low.
    p_reset_quiet_r6: assert property (@(posedge clk)
        !rst_n |=> (!gate_q && !strobe_q));

endmodule : pwm_edge_gen

// File: rtl/trail_pwm.sv
// Module: trail_pwm (top)
// Trailing-edge PWM: gate high from period start for the mapped compare
// count, low for the rest; one-cycle strobe at each period start.
// Assumes: single clock, synchronous active-low reset, control word is
// two's complement with CW_W-1 fraction bits.
module trail_pwm #(
    parameter int unsigned PERIOD  = pwm_pkg::PWM_PERIOD_DEF,
    parameter int unsigned CW_W    = pwm_pkg::PWM_CW_W_DEF,
    parameter int unsigned MIN_CMP = pwm_pkg::PWM_MIN_CMP_DEF,
    parameter int unsigned MAX_CMP = pwm_pkg::PWM_MAX_CMP_DEF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [CW_W-1:0] ctrl_word,
    output logic                   gate_out,
    output logic                   period_start
);

    localparam int unsigned CNT_W = $clog2(PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;
    logic [CNT_W-1:0] cmp_val;
    logic [CNT_W-1:0] cmp_q;

    pwm_period_ctr #(
        .PERIOD (PERIOD),
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    pwm_duty_map #(
        .CW_W    (CW_W),
        .PERIOD  (PERIOD),
        .MIN_CMP (MIN_CMP),
        .MAX_CMP (MAX_CMP),
        .CNT_W   (CNT_W)
    ) u_map (
        .ctrl_word (ctrl_word),
        .cmp_val   (cmp_val)
    );

    pwm_edge_gen #(
        .MIN_CMP (MIN_CMP),
        .MAX_CMP (MAX_CMP),
        .CNT_W   (CNT_W)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .cnt_nxt  (cnt_nxt),
        .cmp_val  (cmp_val),
        .cmp_q    (cmp_q),
        .gate_q   (gate_out),
        .strobe_q (period_start)
    );

    // R4: a negative word captured at a boundary yields the minimum compare.
    p_neg_gives_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ctrl_word[CW_W-1]) |=> (cmp_q == CNT_W'(MIN_CMP)));

    // R1: the strobe marks the zero count.
    p_strobe_at_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |-> (cnt_q == '0));

endmodule : trail_pwm

// File: tb/trail_pwm_bench.sv
// Bench for trail_pwm: directed extremes plus seeded random words; pulse
// widths measured by counting gate-high cycles between strobes.
module trail_pwm_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] ctrl_word = 12'd0;
    logic        gate_out;
    logic        period_start;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    int cur_exp  = 0;

    always #2 clk = ~clk;

    trail_pwm u_trail_pwm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_word    (ctrl_word),
        .gate_out     (gate_out),
        .period_start (period_start)
    );

    // Expected compare count from R3/R4.
    function automatic int exp_cmp(input logic [11:0] w);
        int v;
        if (w[11]) return 9;
        v = (int'(w) * 1000) / 2048;
        if (v < 9) v = 9;
        if (v > 987) v = 987;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Called at a negedge where period_start is high; measures this period.
    task automatic run_period(input int expv, input logic [11:0] junk,
                              input logic [11:0] next_w, input string req);
        int  high = 0;
        int  len = 0;
        int  rises = 0;
        bit  prev = 1'b0;
        bit  first = gate_out;
        do begin
            if (gate_out && !prev) rises++;
            high += int'(gate_out);
            prev = gate_out;
            len++;
            if (len == 300) ctrl_word = junk;
            if (len == 700) ctrl_word = next_w;
            @(negedge clk);
        end while (!period_start && len < 2000);
        check(len == 1000, "R1 period length", len, 1000);
        check(high == expv, req, high, expv);
        check(rises == 1 && first, "R2 single rise at start", rises, 1);
        cur_exp = exp_cmp(next_w);
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        ctrl_word = 12'd885;
        repeat (6) begin
            @(negedge clk);
            check(!gate_out && !period_start, "R6 reset quiet", int'(gate_out), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(period_start == 1'b1, "R7 strobe on first edge", int'(period_start), 1);
        // R5: junk at mid-period must not disturb the running pulse.
        run_period(exp_cmp(12'd885), 12'h800, 12'h7FF, "R8 word 885 -> 432");
        run_period(cur_exp, 12'h000, 12'h000, "R8 word 0x7FF -> 987");
        run_period(cur_exp, 12'h7FF, 12'hFFF, "R8 word 0 -> 9");
        run_period(cur_exp, 12'h7FF, 12'h800, "R4 word -1 -> 9");
        run_period(cur_exp, 12'h7FF, 12'd20, "R4 word min negative -> 9");
        run_period(cur_exp, 12'h800, 12'd2040, "R3 small word clamps to 9");
        run_period(cur_exp, 12'h000, 12'd1024, "R3 word 2040 clamps to 987");
        for (int i = 0; i < 25; i++) begin
            logic [11:0] w = 12'($urandom);
            logic [11:0] j = 12'($urandom);
            run_period(cur_exp, j, w, "R3 R5 random word");
        end
        // Mid-period reset, then restart (R6, R7).
        repeat (123) @(negedge clk);
        rst_n = 1'b0;
        ctrl_word = 12'd1536;
        @(negedge clk);
        check(!gate_out && !period_start, "R6 reset mid-period", int'(gate_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(period_start == 1'b1, "R7 restart strobe", int'(period_start), 1);
        run_period(exp_cmp(12'd1536), 12'h123, 12'd885, "R7 word captured at release");
        run_period(cur_exp, 12'hABC, 12'd885, "R8 word 885 -> 432 again");
        summary();
    end

endmodule : trail_pwm_bench